// File: doc/BRIEF.md
# Display Register Command-Stream Engine

This engine replays a queue of register-write instructions, kept in memory, onto a display register write port. Software first sets the enable bit in the control register. It then writes a head pointer and then a tail pointer. The tail write starts a run. The engine fetches 64-bit instruction words one at a time, from the head position up to the tail. It decodes each word and drives register writes until the fetch position reaches the tail.

Two kinds of instruction exist. A single write carries one data value, a byte-enable mask and a 20-bit register offset. A burst write carries a count N and a register offset; the N data dwords that follow all go to that one offset, in order. Every instruction starts on an 8-byte boundary. A burst with an odd count therefore ends with one zero pad dword, which the engine skips. A zero instruction word is a no-op, so the zero fill software adds to round the tail up to a 64-byte line is harmless. Any other opcode is skipped and raises a sticky error flag.

Top module: `dreg_stream_engine`

## Requirements
- R1: After reset, busy, enable and the error flag are 0, and neither `mem_req` nor `rw_valid` is asserted.
- R2: A configuration write with `cfg_sel`=0 loads the enable bit from `cfg_wdata[0]`. Such a write is ignored while busy is set.
- R3: A tail write (`cfg_sel`=2) while enabled and idle sets busy at the next clock edge. A tail write while disabled stores the pointer but does not start a run, so busy stays 0 and no fetch is issued.
- R4: Pointers are byte addresses whose low 3 bits are ignored. Fetches read consecutive 8-byte words, starting at the head (`cfg_sel`=1), with `mem_addr` = 8 × word position. Only one read is outstanding at a time. In each fetched word, dword 0 is bits [31:0] and dword 1 is bits [63:32].
- R5: Opcode 0x01, in dword 1 bits [31:24], issues one register write. The data is dword 0, the offset is dword 1 bits [19:0] and the byte enables are dword 1 bits [23:20].
- R6: Opcode 0x09 takes a count N from dword 0 and an offset from dword 1 bits [19:0]. It issues N writes to that offset with byte enables 0xF. The data comes from the following dwords in order, the low dword of each word before the high dword.
- R7: When N is odd, the upper dword of the last data word is a pad. It is never written out, and the next instruction starts at the following word.
- R8: A burst with N=0 issues no writes and consumes exactly one 8-byte word.
- R9: Opcode 0x00 is a silent no-op. Any other opcode besides 0x01 and 0x09 is skipped and sets the error flag, which stays set until reset.
- R10: Busy remains set while instructions are processed. It clears once the fetch position equals the tail, even if that happens in the middle of a burst. A run with head equal to tail makes no fetches and no writes.
- R11: Head and tail writes made while busy is set are ignored. A later tail write alone replays from the previously stored head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 control, 1 head, 2 tail |
| cfg_wdata | input | AW | Configuration write data |
| ctrl_enable | output | 1 | Enable bit |
| ctrl_busy | output | 1 | Run in progress |
| ctrl_err | output | 1 | Sticky unknown-opcode flag |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | AW | Byte address of the 8-byte word |
| mem_rvalid | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 64 | Read data |
| rw_valid | output | 1 | Register write strobe |
| rw_addr | output | 20 | Register offset |
| rw_data | output | 32 | Register write data |
| rw_be | output | 4 | Byte enables |

## Verification
Configuration writes land at one clock edge, so busy and the enable bit are sampled at the falling edge that follows. Register writes come out a variable number of cycles after a tail write, because the memory model answers each request after a random delay of one to three cycles. The bench therefore logs every `rw_valid` cycle at falling edges and compares the log with the expected list in order, not by cycle. It waits for busy to fall before comparing, and it also records request addresses to check that they advance by 8.

// File: rtl/dse_pkg.sv
package dse_pkg;

  localparam int OFF_W = 20;

  localparam logic [7:0] OP_NOP    = 8'h00;
  localparam logic [7:0] OP_SINGLE = 8'h01;
  localparam logic [7:0] OP_BURST  = 8'h09;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HEAD = 2'd1;
  localparam logic [1:0] SEL_TAIL = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_EXEC} seq_state_e;

  // Upper dword of an instruction word: the field layout is decoded by hardware.
  typedef struct packed {
    logic [7:0]       op;
    logic [3:0]       be;
    logic [OFF_W-1:0] off;
  } hdr_t;

  function automatic logic op_known(logic [7:0] op);
    return (op == OP_NOP) || (op == OP_SINGLE) || (op == OP_BURST);
  endfunction

  function automatic logic [31:0] lane_pick(logic [63:0] q, logic hi);
    return hi ? q[63:32] : q[31:0];
  endfunction

endpackage

// File: rtl/dse_cfg_regs.sv
module dse_cfg_regs
  import dse_pkg::*;
#(
  parameter int AW = 32,
  localparam int QW = AW - 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          busy,
  output logic          enable_q,
  output logic [QW-1:0] head_q,
  output logic [QW-1:0] tail_q,
  output logic          start
);

  logic cfg_accept;
  logic cfg_unused;

  assign cfg_accept = cfg_wr && !busy;
  assign start      = cfg_accept && (cfg_sel == SEL_TAIL) && enable_q;
  assign cfg_unused = ^cfg_wdata[2:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      head_q   <= '0;
      tail_q   <= '0;
    end else if (cfg_accept) begin
      case (cfg_sel)
        SEL_CTRL: enable_q <= cfg_wdata[0];
        SEL_HEAD: head_q   <= cfg_wdata[AW-1:3];
        SEL_TAIL: tail_q   <= cfg_wdata[AW-1:3];
        default: ;
      endcase
    end
  end

  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(head_q) && $stable(tail_q))); // R11
  AST_ENABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(enable_q)); // R2

endmodule

// File: rtl/dse_sequencer.sv
module dse_sequencer
  import dse_pkg::*;
#(
  parameter int AW = 32,
  localparam int QW = AW - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [QW-1:0]    head_q,
  input  logic [QW-1:0]    tail_q,
  input  logic             mem_rvalid,
  input  logic [63:0]      mem_rdata,
  output logic             busy,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic             rw_valid,
  output logic [OFF_W-1:0] rw_addr,
  output logic [31:0]      rw_data,
  output logic [3:0]       rw_be,
  output logic             err
);

  seq_state_e       state_q;
  logic [QW-1:0]    pos_q;
  logic [63:0]      qw_q;
  logic             in_burst_q;
  logic             lane_q;
  logic [31:0]      remain_q;
  logic [OFF_W-1:0] burst_off_q;
  logic             err_q;
  hdr_t             hdr;

  // Named internal events
  logic fetch_done;
  logic exec_hdr;
  logic exec_data;
  logic last_data;

  assign hdr        = qw_q[63:32];
  assign fetch_done = (state_q == ST_REQ) && (pos_q == tail_q);
  assign exec_hdr   = (state_q == ST_EXEC) && !in_burst_q;
  assign exec_data  = (state_q == ST_EXEC) && in_burst_q;
  assign last_data  = exec_data && (remain_q == 32'd1);

  assign busy     = (state_q != ST_IDLE);
  assign mem_req  = (state_q == ST_REQ) && !fetch_done;
  assign mem_addr = {pos_q, 3'b000};
  assign err      = err_q;

  always_comb begin
    rw_valid = 1'b0;
    rw_addr  = hdr.off;
    rw_data  = qw_q[31:0];
    rw_be    = hdr.be;
    if (exec_data) begin
      rw_valid = 1'b1;
      rw_addr  = burst_off_q;
      rw_data  = lane_pick(qw_q, lane_q);
      rw_be    = 4'hF;
    end else if (exec_hdr && (hdr.op == OP_SINGLE)) begin
      rw_valid = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pos_q       <= '0;
      qw_q        <= '0;
      in_burst_q  <= 1'b0;
      lane_q      <= 1'b0;
      remain_q    <= '0;
      burst_off_q <= '0;
      err_q       <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q    <= ST_REQ;
            pos_q      <= head_q;
            in_burst_q <= 1'b0;
            lane_q     <= 1'b0;
          end
        end
        ST_REQ: begin
          state_q <= fetch_done ? ST_IDLE : ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rvalid) begin
            qw_q    <= mem_rdata;
            pos_q   <= pos_q + 1'b1;
            lane_q  <= 1'b0;
            state_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (in_burst_q) begin
            remain_q <= remain_q - 32'd1;
            if (last_data) begin
              in_burst_q <= 1'b0;
              state_q    <= ST_REQ;
            end else if (!lane_q) begin
              lane_q <= 1'b1;
            end else begin
              state_q <= ST_REQ;
            end
          end else begin
            state_q <= ST_REQ;
            if (!op_known(hdr.op)) begin
              err_q <= 1'b1;
            end else if ((hdr.op == OP_BURST) && (qw_q[31:0] != 32'd0)) begin
              in_burst_q  <= 1'b1;
              remain_q    <= qw_q[31:0];
              burst_off_q <= hdr.off;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R10
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R9
  AST_STOP_AT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(pos_q) == $past(tail_q))); // R10
  AST_NO_WRITE_DURING_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    rw_valid |-> !mem_req); // R5

endmodule

// File: rtl/dreg_stream_engine.sv
module dreg_stream_engine
  import dse_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          ctrl_enable,
  output logic          ctrl_busy,
  output logic          ctrl_err,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata,
  output logic          rw_valid,
  output logic [19:0]   rw_addr,
  output logic [31:0]   rw_data,
  output logic [3:0]    rw_be
);

  localparam int QW = AW - 3;

  logic [QW-1:0] head_w;
  logic [QW-1:0] tail_w;
  logic          start_w;
  logic          busy_w;

  dse_cfg_regs #(.AW(AW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .busy     (busy_w),
    .enable_q (ctrl_enable),
    .head_q   (head_w),
    .tail_q   (tail_w),
    .start    (start_w)
  );

  dse_sequencer #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .head_q    (head_w),
    .tail_q    (tail_w),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata),
    .busy      (busy_w),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .rw_valid  (rw_valid),
    .rw_addr   (rw_addr),
    .rw_data   (rw_data),
    .rw_be     (rw_be),
    .err       (ctrl_err)
  );

  assign ctrl_busy = busy_w;

endmodule

// File: tb/dreg_stream_engine_test.sv
module dreg_stream_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        ctrl_enable, ctrl_busy, ctrl_err;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        rw_valid;
  logic [19:0] rw_addr;
  logic [31:0] rw_data;
  logic [3:0]  rw_be;

  always #10 clk = ~clk;

  dreg_stream_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctrl_enable(ctrl_enable), .ctrl_busy(ctrl_busy), .ctrl_err(ctrl_err),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rw_valid(rw_valid), .rw_addr(rw_addr), .rw_data(rw_data), .rw_be(rw_be)
  );

  int n_checks = 0;
  int n_fail = 0;

  logic [63:0] mem [0:511];
  logic        pend = 1'b0;
  logic [8:0]  pend_idx = '0;
  int          pend_wait = 0;

  // Memory model: answers each request after 1 to 3 cycles.
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend) begin
      if (pend_wait == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[pend_idx];
        pend       = 1'b0;
      end else pend_wait--;
    end
    if (mem_req) begin
      pend      = 1'b1;
      pend_idx  = mem_addr[11:3];
      pend_wait = $urandom_range(0, 2);
    end
  end

  // Logs of observed register writes and fetch addresses.
  logic [19:0] log_addr [0:2047];
  logic [31:0] log_data [0:2047];
  logic [3:0]  log_be   [0:2047];
  int          log_n = 0;
  logic [31:0] req_addr [0:2047];
  int          req_n = 0;

  always @(negedge clk) begin
    if (rw_valid && log_n < 2048) begin
      log_addr[log_n] = rw_addr;
      log_data[log_n] = rw_data;
      log_be[log_n]   = rw_be;
      log_n++;
    end
    if (mem_req && req_n < 2048) begin
      req_addr[req_n] = mem_addr;
      req_n++;
    end
  end

  logic [19:0] exp_addr [0:2047];
  logic [31:0] exp_data [0:2047];
  logic [3:0]  exp_be   [0:2047];
  int          exp_n = 0;
  int          wpos = 0;

  function automatic int line_round(int p);
    return ((p + 7) / 8) * 8;
  endfunction

  function automatic logic [63:0] make_word(logic [7:0] op, logic [3:0] be,
                                            logic [19:0] off, logic [31:0] lo);
    return {op, be, off, lo};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic push_exp(input logic [19:0] a, input logic [31:0] d, input logic [3:0] b);
    exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_be[exp_n] = b; exp_n++;
  endtask

  task automatic emit_single(input logic [19:0] a, input logic [31:0] d, input logic [3:0] b);
    mem[wpos] = make_word(8'h01, b, a, d);
    wpos++;
    push_exp(a, d, b);
  endtask

  task automatic emit_burst(input logic [19:0] a, input int n);
    mem[wpos] = make_word(8'h09, 4'h0, a, n);
    wpos++;
    for (int i = 0; i < n; i++) begin
      logic [31:0] v = $urandom;
      if (i % 2 == 0) mem[wpos] = {32'h0, v};
      else begin
        mem[wpos][63:32] = v;
        wpos++;
      end
      push_exp(a, v, 4'hF);
    end
    if (n % 2 == 1) wpos++;
  endtask

  task automatic emit_raw(input logic [63:0] w);
    mem[wpos] = w;
    wpos++;
  endtask

  task automatic pad_line();
    int e = line_round(wpos);
    while (wpos < e) begin
      mem[wpos] = '0;
      wpos++;
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      if (!ctrl_busy) break;
      @(negedge clk);
    end
    check(!ctrl_busy, "R10 busy clears", ctrl_busy, 0);
  endtask

  task automatic compare_log(input string tag);
    check(log_n == exp_n, {tag, " write count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      check(log_addr[i] == exp_addr[i], {tag, " addr"}, log_addr[i], exp_addr[i]);
      check(log_data[i] == exp_data[i], {tag, " data"}, log_data[i], exp_data[i]);
      check(log_be[i] == exp_be[i], {tag, " be"}, log_be[i], exp_be[i]);
    end
  endtask

  task automatic clear_logs();
    log_n = 0; req_n = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!ctrl_busy, "R1 busy", ctrl_busy, 0);
    check(!ctrl_enable, "R1 enable", ctrl_enable, 0);
    check(!ctrl_err, "R1 err", ctrl_err, 0);
    check(!mem_req && !rw_valid, "R1 idle ports", {mem_req, rw_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed program at word 0: single with partial enables, odd burst,
    // zero burst, no-op, even burst, single.
    wpos = 0; exp_n = 0;
    emit_single(20'h12345, 32'hCAFE0001, 4'h5);
    emit_burst(20'h00A10, 3);
    emit_burst(20'h00B20, 0);
    emit_raw(64'h0);
    emit_burst(20'h00C30, 4);
    emit_single(20'hFFFFF, 32'h0BADF00D, 4'hF);
    pad_line();

    // R3: tail write while disabled does not start
    clear_logs();
    cfg_write(2'd1, 32'h0);
    cfg_write(2'd2, wpos * 8);
    check(!ctrl_busy, "R3 no start when disabled", ctrl_busy, 0);
    repeat (4) @(negedge clk);
    check(req_n == 0, "R3 no fetch when disabled", req_n, 0);

    // R2 enable
    cfg_write(2'd0, 32'h1);
    check(ctrl_enable, "R2 enable set", ctrl_enable, 1);

    // R3/R4: start with low pointer bits set (ignored); R11 writes while busy
    cfg_write(2'd1, 32'h3);
    cfg_write(2'd2, wpos * 8 + 5);
    check(ctrl_busy, "R3 busy after tail", ctrl_busy, 1);
    cfg_write(2'd1, 32'h400);
    cfg_write(2'd2, 32'h408);
    cfg_write(2'd0, 32'h0);
    wait_idle();
    check(ctrl_enable, "R2 enable write ignored while busy", ctrl_enable, 1);
    compare_log("R5 R6 R7 R8 R11 directed");
    check(req_n == wpos, "R4 fetch count", req_n, wpos);
    for (int i = 0; i < req_n; i++)
      check(req_addr[i] == i * 8, "R4 fetch address", req_addr[i], i * 8);
    check(!ctrl_err, "R9 no-op leaves err clear", ctrl_err, 0);

    // R11: tail write alone replays from the stored head
    clear_logs();
    cfg_write(2'd2, wpos * 8);
    wait_idle();
    compare_log("R11 replay");

    // R10: head equal to tail
    clear_logs();
    cfg_write(2'd1, 32'h200);
    cfg_write(2'd2, 32'h200);
    wait_idle();
    check(log_n == 0 && req_n == 0, "R10 empty run", log_n + req_n, 0);

    // R10: tail in the middle of a burst truncates
    wpos = 64; exp_n = 0;
    emit_burst(20'h00D00, 6);
    clear_logs();
    exp_n = 2;
    cfg_write(2'd1, 64 * 8);
    cfg_write(2'd2, 66 * 8);
    wait_idle();
    compare_log("R10 truncated burst");

    // R9: unknown opcode skipped, err sticky
    wpos = 96; exp_n = 0;
    emit_raw(make_word(8'h33, 4'hF, 20'h00E00, 32'h1111));
    emit_single(20'h00E04, 32'h2222, 4'hF);
    pad_line();
    clear_logs();
    cfg_write(2'd1, 96 * 8);
    cfg_write(2'd2, wpos * 8);
    wait_idle();
    compare_log("R9 unknown skipped");
    check(ctrl_err, "R9 err set", ctrl_err, 1);

    // Random programs
    for (int t = 0; t < 24; t++) begin
      int k;
      base = (t % 3) * 128;
      wpos = base; exp_n = 0;
      k = $urandom_range(1, 10);
      for (int j = 0; j < k; j++) begin
        case ($urandom_range(0, 2))
          0: emit_single(20'($urandom), $urandom, 4'($urandom));
          1: emit_burst(20'($urandom), $urandom_range(0, 6));
          default: emit_raw(64'h0);
        endcase
      end
      pad_line();
      clear_logs();
      cfg_write(2'd1, base * 8);
      cfg_write(2'd2, wpos * 8);
      wait_idle();
      compare_log("R5 R6 R7 R8 random");
      check(req_n == wpos - base, "R4 random fetch count", req_n, wpos - base);
    end
    check(ctrl_err, "R9 err sticky", ctrl_err, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule